// File: doc/BRIEF.md
# PCI Target Abort Handler

This block sits on the target side of a PCI/PCI-X bridge's address translation path. It decides how each inbound transaction ends. It can complete a normal data phase, or it can end the transaction with a target abort. A write that lands in the read-only expansion ROM window is aborted at once, and no internal-bus cycle is issued for it. A read first issues an internal-bus cycle and waits for the response. If that cycle ends in a master abort, or in a target abort from the memory controller (an uncorrectable multi-bit ECC error), the PCI read is target-aborted. Any other read, and any write outside the ROM window, completes with one data phase.

Every target abort the block signals is logged in two places. The first is a sticky, write-one-to-clear bit in a 16-bit status register. The second is an interrupt status bit, which is set only while the matching mask input is clear. An interrupt request is raised from the unmasked interrupt status. On the initiator side, in PCI-X mode, a split completion that the far target aborts is simply dropped. The drop is shown by a one-cycle pulse, and it leaves the logs and the interrupt untouched.

Top module: `tabort_unit`

## Requirements
- R1: An abort phase drives devsel_n=1, trdy_n=1 and stop_n=0 together for exactly one cycle. In the next cycle all three are 1 (bus idle).
- R2: A request accepted while idle with req_write=1 and req_rom_hit=1 does not pulse ib_req. The abort phase appears in the cycle after the request.
- R3: Any other accepted request pulses ib_req in its own cycle. A read then holds devsel_n=0, trdy_n=1, stop_n=1 until ib_done.
- R4: When ib_done arrives with ib_mabort=1 or ib_tabort=1, the next cycle is an abort phase. A clean ib_done, or a write outside the ROM window, gives one data phase (devsel_n=0, trdy_n=0, stop_n=1) in the next cycle.
- R5: status bit 11 (target abort signalled) reads 1 from the cycle after an abort phase and stays set. All other status bits read 0. Everything is 0 after reset.
- R6: isr (target abort signalled) is set by an abort phase only when irq_mask=0 in that cycle. When irq_mask=1 it is left unchanged.
- R7: csr_wr_stat clears each status bit whose csr_wdata bit is 1. csr_wr_isr clears isr when csr_wdata[0]=1. An abort phase in the same cycle wins over the clear.
- R8: irq is 1 exactly when isr=1 and irq_mask=0.
- R9: With pcix_mode=1, sc_tabort gives a one-cycle sc_discard pulse in the next cycle. It does not change status, isr or irq.
- R10: With pcix_mode=0, sc_tabort is ignored and sc_discard stays 0.
- R11: req_valid is ignored while a transaction is in progress (any bus signal low). It gives no ib_req and does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional PCI |
| req_valid | input | 1 | Inbound transaction decoded this cycle |
| req_write | input | 1 | 1 = inbound write, 0 = read |
| req_rom_hit | input | 1 | Address claimed by the expansion ROM window |
| ib_req | output | 1 | Start an internal-bus cycle |
| ib_done | input | 1 | Internal-bus cycle finished |
| ib_mabort | input | 1 | Internal-bus cycle ended in master abort |
| ib_tabort | input | 1 | Internal-bus cycle ended in target abort (ECC) |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop, active low |
| sc_tabort | input | 1 | Far target aborted an outgoing split completion |
| sc_discard | output | 1 | Split completion dropped |
| irq_mask | input | 1 | Mask for the target-abort interrupt |
| csr_wr_stat | input | 1 | Write-one-to-clear strobe for status |
| csr_wr_isr | input | 1 | Write-one-to-clear strobe for isr |
| csr_wdata | input | 16 | Clear data for the strobes |
| status | output | 16 | Status register, bit 11 = target abort signalled |
| isr | output | 1 | Interrupt status, target abort signalled |
| irq | output | 1 | Interrupt request |

## Verification
The bench exercises each corner case below, and each one shows a specific design fault:
- A clear strobe that lands in the very cycle of an abort phase. A design where the clear wins would lose an event.
- Aborts taken while the mask is set. A design that ignores the mask would set isr and raise irq.
- Clear writes with the wrong bit. A design that clears on any write would drop the sticky status.
- Requests arriving mid-transaction. A design that accepts them would issue a stray internal-bus cycle.
- Aborted split completions in both modes. A design that logs them would set status bit 11, and one that ignores the mode would pulse sc_discard in conventional PCI.
- ROM-window writes. A design that forwards them would show ib_req going high.

// File: rtl/ta_pkg.sv
// Shared constants and types for the target abort handler.
// Assumes a 16-bit status register with the abort flag at bit 11.
package ta_pkg;
    localparam int STAT_W  = 16;
    localparam int TA_BIT  = 11;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_WAIT  = 2'd1,
        TS_DATA  = 2'd2,
        TS_ABORT = 2'd3
    } tgt_st_e;
endpackage

// File: rtl/ta_tgt_fsm.sv
// Target-side sequencer: accepts an inbound request while idle, issues the
// internal-bus cycle when one is needed, and chooses between a single data
// phase and a single abort phase. Assumes the internal-bus outcome flags are
// valid in the ib_done cycle only.
module ta_tgt_fsm
    import ta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_rom_hit,
    input  logic ib_done,
    input  logic ib_mabort,
    input  logic ib_tabort,
    output logic ib_req,
    output logic devsel_n,
    output logic trdy_n,
    output logic stop_n,
    output logic abort_ev
);
    tgt_st_e st_q, st_d;
    logic    rom_wr;

    // Writes into the read-only ROM window never reach the internal bus
    assign rom_wr = req_write & req_rom_hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_IDLE;
        else        st_q <= st_d;
    end

    // Next-state choice
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE: begin
                if (req_valid) begin
                    if (rom_wr)         st_d = TS_ABORT;
                    else if (req_write) st_d = TS_DATA;
                    else                st_d = TS_WAIT;
                end
            end
            TS_WAIT: begin
                if (ib_done) st_d = (ib_mabort | ib_tabort) ? TS_ABORT : TS_DATA;
            end
            TS_DATA:  st_d = TS_IDLE;
            TS_ABORT: st_d = TS_IDLE;
            default:  st_d = TS_IDLE;
        endcase
    end

    // Bus signalling and internal-bus launch decoded from the state
    always_comb begin
        ib_req   = (st_q == TS_IDLE) & req_valid & ~rom_wr;
        devsel_n = ~((st_q == TS_WAIT) | (st_q == TS_DATA));
        trdy_n   = ~(st_q == TS_DATA);
        stop_n   = ~(st_q == TS_ABORT);
        abort_ev = (st_q == TS_ABORT);
    end
endmodule

// File: rtl/ta_log.sv
// Status and interrupt-status logging for signalled target aborts. Every
// status bit is sticky write-one-to-clear; a set event beats a clear in the
// same cycle. Assumes only the abort flag has a set source.
module ta_log #(
    parameter int STAT_W = 16,
    parameter int TA_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_ev,
    input  logic              irq_mask,
    input  logic              csr_wr_stat,
    input  logic              csr_wr_isr,
    input  logic [STAT_W-1:0] csr_wdata,
    output logic [STAT_W-1:0] status,
    output logic              isr,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;
    logic              isr_q;

    // Set sources: only the abort flag position is driven
    always_comb begin
        set_vec         = '0;
        set_vec[TA_BIT] = abort_ev;
    end

    // One sticky W1C cell per status bit
    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_vec[b]) bit_q <= 1'b1;
            else if (csr_wr_stat && csr_wdata[b]) bit_q <= 1'b0;
        end
        assign status[b] = bit_q;
    end

    // Interrupt status: set only through a clear mask, W1C on bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                          isr_q <= 1'b0;
        else if (abort_ev && !irq_mask)      isr_q <= 1'b1;
        else if (csr_wr_isr && csr_wdata[0]) isr_q <= 1'b0;
    end

    assign isr = isr_q;
    assign irq = isr_q & ~irq_mask;
endmodule

// File: rtl/ta_split_drop.sv
// Initiator-side filter for split completions aborted by the far target: in
// PCI-X mode the completion is dropped and a one-cycle marker is produced;
// conventional mode never sees this path, so the strobe is ignored there.
module ta_split_drop (
    input  logic clk,
    input  logic rst_n,
    input  logic pcix_mode,
    input  logic sc_tabort,
    output logic sc_discard
);
    // Register the drop marker
    always_ff @(posedge clk) begin
        if (!rst_n) sc_discard <= 1'b0;
        else        sc_discard <= pcix_mode & sc_tabort;
    end
endmodule

// File: rtl/tabort_unit.sv
// Top of the target abort handler: ties the target sequencer, the abort
// log and the split-completion filter together. Assumes decode and the
// internal bus present single-cycle strobes.
module tabort_unit
    import ta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcix_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_rom_hit,
    output logic              ib_req,
    input  logic              ib_done,
    input  logic              ib_mabort,
    input  logic              ib_tabort,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    input  logic              sc_tabort,
    output logic              sc_discard,
    input  logic              irq_mask,
    input  logic              csr_wr_stat,
    input  logic              csr_wr_isr,
    input  logic [STAT_W-1:0] csr_wdata,
    output logic [STAT_W-1:0] status,
    output logic              isr,
    output logic              irq
);
    logic abort_ev;

    ta_tgt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_rom_hit(req_rom_hit),
        .ib_done    (ib_done),
        .ib_mabort  (ib_mabort),
        .ib_tabort  (ib_tabort),
        .ib_req     (ib_req),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .abort_ev   (abort_ev)
    );

    ta_log #(.STAT_W(STAT_W), .TA_BIT(TA_BIT)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_ev   (abort_ev),
        .irq_mask   (irq_mask),
        .csr_wr_stat(csr_wr_stat),
        .csr_wr_isr (csr_wr_isr),
        .csr_wdata  (csr_wdata),
        .status     (status),
        .isr        (isr),
        .irq        (irq)
    );

    ta_split_drop u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .pcix_mode (pcix_mode),
        .sc_tabort (sc_tabort),
        .sc_discard(sc_discard)
    );
endmodule

// File: rtl/ta_abort_chk.sv
// Property checker for the target abort handler, attached by bind.
module ta_abort_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pcix_mode,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_rom_hit,
    input logic        ib_req,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        sc_tabort,
    input logic        sc_discard,
    input logic        irq_mask,
    input logic [15:0] status,
    input logic        isr
);
    logic bus_idle;
    assign bus_idle = devsel_n & trdy_n & stop_n;

    AST_ABORT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> (devsel_n && trdy_n)); // R1
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |=> (devsel_n && trdy_n && stop_n)); // R1
    AST_ROM_WR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && req_valid && req_write && req_rom_hit) |=> !stop_n); // R2
    AST_ROM_WR_NO_IB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && req_rom_hit) |-> !ib_req); // R2
    AST_STATUS_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |=> status[11]); // R5
    AST_MASK_HOLDS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && irq_mask && !isr) |=> !isr); // R6
    AST_SPLIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_tabort && stop_n && !status[11]) |=> !status[11]); // R9
    AST_SPLIT_CONV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_tabort && !pcix_mode) |=> !sc_discard); // R10
    AST_BUSY_NO_IB: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |-> !ib_req); // R11
endmodule

bind tabort_unit ta_abort_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pcix_mode  (pcix_mode),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_rom_hit(req_rom_hit),
    .ib_req     (ib_req),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .sc_tabort  (sc_tabort),
    .sc_discard (sc_discard),
    .irq_mask   (irq_mask),
    .status     (status),
    .isr        (isr)
);

// File: tb/sim_tabort_unit.sv
`timescale 1ns/1ps
module sim_tabort_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pcix_mode = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_rom_hit = 1'b0;
    logic        ib_done = 1'b0, ib_mabort = 1'b0, ib_tabort = 1'b0;
    logic        sc_tabort = 1'b0, irq_mask = 1'b0;
    logic        csr_wr_stat = 1'b0, csr_wr_isr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic        ib_req, devsel_n, trdy_n, stop_n, sc_discard, isr, irq;
    logic [15:0] status;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tabort_unit u0 (.*);

    // Behavioural reference: phase number plus expected logs
    int m_ph = 0;          // 0 idle, 1 waiting, 2 data, 3 abort
    bit m_stat = 0, m_isr = 0, m_disc = 0, armed = 0;

    always @(posedge clk) begin
        armed <= 1;
        if (!rst_n) begin
            m_ph <= 0; m_stat <= 0; m_isr <= 0; m_disc <= 0;
        end else begin
            if (m_ph == 0 && req_valid)
                m_ph <= (req_write && req_rom_hit) ? 3 : (req_write ? 2 : 1);
            else if (m_ph == 1 && ib_done)
                m_ph <= (ib_mabort || ib_tabort) ? 3 : 2;
            else if (m_ph >= 2)
                m_ph <= 0;
            if (m_ph == 3) m_stat <= 1;
            else if (csr_wr_stat && csr_wdata[11]) m_stat <= 0;
            if (m_ph == 3 && !irq_mask) m_isr <= 1;
            else if (csr_wr_isr && csr_wdata[0]) m_isr <= 0;
            m_disc <= pcix_mode && sc_tabort;
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (armed) begin
            chk("R1 stop_n",      16'(stop_n),    16'(m_ph != 3));
            chk("R3 devsel_n",    16'(devsel_n),  16'(!(m_ph == 1 || m_ph == 2)));
            chk("R4 trdy_n",      16'(trdy_n),    16'(m_ph != 2));
            chk("R3 ib_req",      16'(ib_req),
                16'(m_ph == 0 && req_valid && !(req_write && req_rom_hit)));
            chk("R5 status",      status,         16'(m_stat) << 11);
            chk("R6 isr",         16'(isr),       16'(m_isr));
            chk("R8 irq",         16'(irq),       16'(m_isr && !irq_mask));
            chk("R9 sc_discard",  16'(sc_discard),16'(m_disc));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle_in();
        req_valid = 0; req_write = 0; req_rom_hit = 0;
        ib_done = 0; ib_mabort = 0; ib_tabort = 0;
        sc_tabort = 0; csr_wr_stat = 0; csr_wr_isr = 0; csr_wdata = '0;
    endtask

    task automatic read_with(input int lat, input bit ma, input bit ta);
        req_valid = 1; req_write = 0; req_rom_hit = 0;
        step(); idle_in();
        repeat (lat) step();
        ib_done = 1; ib_mabort = ma; ib_tabort = ta;
        step(); idle_in();
    endtask

    initial begin
        repeat (3) step();
        @(negedge clk);
        chk("R5 reset status", status, 16'h0000);
        chk("R1 reset stop_n", 16'(stop_n), 16'h1);
        step(); rst_n = 1; step();

        // ROM-window write: no internal cycle, abort next cycle
        req_valid = 1; req_write = 1; req_rom_hit = 1;
        @(negedge clk); chk("R2 no ib_req on ROM write", 16'(ib_req), 16'h0);
        step(); idle_in();
        @(negedge clk); chk("R2 abort after ROM write", 16'(stop_n), 16'h0);
        step();
        @(negedge clk); chk("R1 idle after abort", 16'({devsel_n, trdy_n, stop_n}), 16'h7);
        chk("R6 isr set unmasked", 16'(isr), 16'h1);

        // Wrong-bit clear keeps status; right bit clears it
        csr_wr_stat = 1; csr_wdata = 16'h0400; step(); idle_in();
        @(negedge clk); chk("R7 wrong bit keeps status", status, 16'h0800);
        csr_wr_stat = 1; csr_wdata = 16'h0800; step(); idle_in();
        @(negedge clk); chk("R7 status cleared", status, 16'h0000);
        csr_wr_isr = 1; csr_wdata = 16'h0001; step(); idle_in();
        @(negedge clk); chk("R7 isr cleared", 16'(isr), 16'h0);

        // Clean read after 3 wait cycles: data phase
        read_with(3, 0, 0);
        @(negedge clk); chk("R4 data phase trdy_n", 16'(trdy_n), 16'h0);
        step(); step();

        // Master abort with mask set: status set, isr not
        irq_mask = 1;
        read_with(1, 1, 0);
        @(negedge clk); chk("R4 master abort -> stop", 16'(stop_n), 16'h0);
        step();
        @(negedge clk); chk("R6 masked isr stays 0", 16'(isr), 16'h0);
        irq_mask = 0; step();

        // Target abort with clear in the abort cycle: set wins
        read_with(0, 0, 1);
        csr_wr_stat = 1; csr_wr_isr = 1; csr_wdata = 16'hFFFF;
        step(); idle_in();
        @(negedge clk); chk("R7 set beats clear", status, 16'h0800);
        chk("R7 isr set beats clear", 16'(isr), 16'h1);

        // Mask toggling gates irq only
        irq_mask = 1; step();
        @(negedge clk); chk("R8 irq masked", 16'(irq), 16'h0);
        irq_mask = 0; step();
        @(negedge clk); chk("R8 irq unmasked", 16'(irq), 16'h1);
        csr_wr_stat = 1; csr_wr_isr = 1; csr_wdata = 16'hFFFF; step(); idle_in();

        // Plain write outside ROM window
        req_valid = 1; req_write = 1;
        @(negedge clk); chk("R3 ib_req on write", 16'(ib_req), 16'h1);
        step(); idle_in();
        @(negedge clk); chk("R4 write data phase", 16'(trdy_n), 16'h0);
        step();

        // Request while busy is ignored
        req_valid = 1; step();
        req_valid = 1; req_write = 1; req_rom_hit = 1;
        @(negedge clk); chk("R11 busy request no ib_req", 16'(ib_req), 16'h0);
        step(); idle_in();
        @(negedge clk); chk("R11 still waiting", 16'(stop_n), 16'h1);
        ib_done = 1; step(); idle_in(); step(); step();

        // Split completion aborts in both modes
        sc_tabort = 1; step(); idle_in();
        @(negedge clk); chk("R9 discard pulse", 16'(sc_discard), 16'h1);
        chk("R9 status untouched", status, 16'h0000);
        pcix_mode = 0; sc_tabort = 1; step(); idle_in();
        @(negedge clk); chk("R10 conventional ignored", 16'(sc_discard), 16'h0);
        step(); step();

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule